// File: doc/BRIEF.md
# Prioritized Nested Interrupt Controller

This block gathers interrupt requests from a set of peripheral sources. It chooses one source to present to a processor core and hands the core a vector address and a 2-bit priority code. Each source has its own register that sets a 2-bit priority level, an enable bit and a trigger mode, which is either edge or level. The core supplies a 2-bit mask threshold. A source is eligible when it is pending, enabled, and its level is at or above that threshold. The highest eligible level wins. When two sources share that level, the lower source index wins.

The vector address is the base-address register placed above the winning source index. This gives each source its own slot in the vector table. The controller registers its choice and holds it until the core acknowledges. The acknowledge clears the pending bit of an edge-mode source and frees the output for the next choice. Nesting follows from the mask. While the core services a request, it raises its mask, and the controller keeps offering any request whose level clears the new threshold.

Two match registers each hold a vector number and a valid bit. A winner at level 2 whose index matches a valid match register is flagged as fast on its own output. All registers are reached through a synchronous register bus. Writes take effect at the clock edge. Reads return data one cycle after the request.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, irq_prio is 00, irq_fast is 0 and irq_vec_addr is 0. The base register, both match registers and every source register read back as 0, so every source starts disabled.
- R2: irq_vec_addr equals the base register (address 0, bits [BASE_W-1:0]) shifted left by VEC_W bits, plus the winning source index.
- R3: A source is eligible only when its level is greater than or equal to core_mask. Mask 00 admits levels 0 to 3, 01 admits levels 1 to 3, 10 admits levels 2 and 3, and 11 admits only level 3.
- R4: irq_prio is 00 when nothing is presented. It is 01 for a level-0 winner, 10 for a level-1 winner and 11 for a level-2 or level-3 winner.
- R5: Among the eligible sources, the highest level wins. A tie within that level goes to the lowest source index.
- R6: A source whose enable bit (bit 2 of its register at address 4+i) is 0 is never presented, even while it is pending.
- R7: Once presented, irq_prio, irq_vec_addr and irq_fast hold unchanged until irq_ack is high at a clock edge. After that edge irq_prio is 00, and a new choice appears one edge later. An acknowledge while irq_prio is 00 has no effect.
- R8: Source register bit 3 selects the mode: 1 means edge, 0 means level. An edge-mode source becomes pending on a rising edge of its request and stays pending until it is acknowledged. A level-mode source is pending while its request is high. A request sampled at one edge can be presented at the next edge.
- R9: irq_fast is 1 only when the winner's level is 2 and a match register with its valid bit set holds the winner's index. Match registers sit at addresses 1 and 2, with the vector in the low bits and the valid bit in bit 15.
- R10: While an earlier request is in service and the core has raised core_mask, a request whose level clears the new mask is presented. A request whose level does not clear it is withheld.
- R11: A register written at one edge reads back its stored bits on bus_rdata one cycle after a read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid one cycle after bus_rd |
| irq_req | input | NUM_SRC | Request lines, one per source |
| core_mask | input | 2 | Core mask threshold |
| irq_ack | input | 1 | Core acknowledge of the presented request |
| irq_vec_addr | output | BASE_W+VEC_W | Vector address of the presented request |
| irq_prio | output | 2 | Encoded priority presented to the core |
| irq_fast | output | 1 | Presented request is a fast interrupt |

## Verification
A request sampled at edge N sets its pending bit at N. The presented outputs load at N+1, so the bench drives requests at a falling edge and checks the outputs at the second falling edge after that. A bus write counts at its own edge, and a read result is sampled at the falling edge after the edge that captured it. After an acknowledge edge the bench expects irq_prio 00 at the next falling edge and the next winner one edge later. The mask and configuration sweep waits three edges before it compares outputs. This is safe because a presented result holds until it is acknowledged.

// File: rtl/prio_irq_pkg.sv
// prio_irq_pkg: types and helpers shared by the interrupt controller.
// Assumes a 2-bit priority level where a larger value is more urgent.
package prio_irq_pkg;

    // Number of fast-interrupt match registers.
    localparam int FAST_N   = 2;
    // First bus address of the per-source registers.
    localparam int SRC_BASE = 4;

    // Per-source configuration held in the register file.
    typedef struct packed {
        logic       edge_mode;  // 1: edge-triggered, 0: level
        logic       enable;
        logic [1:0] level;
    } src_cfg_t;

    // Encoded priority code for the core.
    function automatic logic [1:0] prio_code(input logic valid, input logic [1:0] lvl);
        if (!valid)          return 2'b00;
        else if (lvl == 2'd0) return 2'b01;
        else if (lvl == 2'd1) return 2'b10;
        else                  return 2'b11;
    endfunction

endpackage

// File: rtl/irq_regfile.sv
// irq_regfile: bus-visible registers (base address, fast match, per-source config).
// Assumes single-cycle writes and registered reads; unused addresses read 0.
module irq_regfile
    import prio_irq_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int VEC_W   = 3,
    parameter int BASE_W  = 10,
    parameter int ADDR_W  = 5,
    parameter int DATA_W  = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           bus_wr,
    input  logic                           bus_rd,
    input  logic [ADDR_W-1:0]              bus_addr,
    input  logic [DATA_W-1:0]              bus_wdata,
    output logic [DATA_W-1:0]              bus_rdata,
    output logic [BASE_W-1:0]              base_o,
    output logic [FAST_N-1:0][VEC_W-1:0]   fm_vec_o,
    output logic [FAST_N-1:0]              fm_valid_o,
    output src_cfg_t [NUM_SRC-1:0]         cfg_o
);

    localparam logic [ADDR_W-1:0] ADDR_BASE = '0;
    localparam int VALID_BIT = DATA_W - 1;

    logic [DATA_W-1:0] rd_mux;

    // Base address register.
    always_ff @(posedge clk) begin
        if (!rst_n)                             base_o <= '0;
        else if (bus_wr && bus_addr == ADDR_BASE) base_o <= bus_wdata[BASE_W-1:0];
    end

    // Fast-interrupt match registers, one per generate slot.
    for (genvar f = 0; f < FAST_N; f++) begin : g_fast
        localparam logic [ADDR_W-1:0] ADDR_F = ADDR_W'(1 + f);
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                fm_vec_o[f]   <= '0;
                fm_valid_o[f] <= 1'b0;
            end else if (bus_wr && bus_addr == ADDR_F) begin
                fm_vec_o[f]   <= bus_wdata[VEC_W-1:0];
                fm_valid_o[f] <= bus_wdata[VALID_BIT];
            end
        end
    end

    // Per-source configuration registers.
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        localparam logic [ADDR_W-1:0] ADDR_S = ADDR_W'(SRC_BASE + i);
        always_ff @(posedge clk) begin
            if (!rst_n)                            cfg_o[i] <= '0;
            else if (bus_wr && bus_addr == ADDR_S) cfg_o[i] <= bus_wdata[3:0];
        end
    end

    // Read multiplexer over all registers.
    always_comb begin
        rd_mux = '0;
        if (bus_addr == ADDR_BASE) rd_mux[BASE_W-1:0] = base_o;
        for (int f = 0; f < FAST_N; f++) begin
            if (bus_addr == ADDR_W'(1 + f)) begin
                rd_mux[VEC_W-1:0] = fm_vec_o[f];
                rd_mux[VALID_BIT] = fm_valid_o[f];
            end
        end
        for (int i = 0; i < NUM_SRC; i++) begin
            if (bus_addr == ADDR_W'(SRC_BASE + i)) rd_mux[3:0] = cfg_o[i];
        end
    end

    // Registered read data.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end

    // A base write is visible on the register the next cycle.
    assert_base_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_BASE) |=> (base_o == $past(bus_wdata[BASE_W-1:0])));

endmodule

// File: rtl/irq_pending.sv
// irq_pending: per-source pending state for edge and level request modes.
// Assumes requests are synchronous to clk; the acknowledge clear is one-hot.
module irq_pending
    import prio_irq_pkg::*;
#(
    parameter int NUM_SRC = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_SRC-1:0]     req_i,
    input  src_cfg_t [NUM_SRC-1:0] cfg_i,
    input  logic [NUM_SRC-1:0]     ack_clr_i,
    output logic [NUM_SRC-1:0]     pend_o
);

    logic [NUM_SRC-1:0] req_q;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_pend
        // Track the previous request and update the pending bit by mode.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                req_q[i]  <= 1'b0;
                pend_o[i] <= 1'b0;
            end else begin
                req_q[i] <= req_i[i];
                if (!cfg_i[i].edge_mode) pend_o[i] <= req_i[i];
                else pend_o[i] <= (req_i[i] & ~req_q[i]) | (pend_o[i] & ~ack_clr_i[i]);
            end
        end

        // Pending can only be raised by a request seen at that edge.
        assert_pend_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pend_o[i]) |-> $past(req_i[i]));

        // An acknowledged edge source without a new edge is cleared.
        assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_i[i].edge_mode && ack_clr_i[i] && !(req_i[i] && !req_q[i])) |=> !pend_o[i]);
    end

endmodule

// File: rtl/irq_arbiter.sv
// irq_arbiter: combinational choice of the highest eligible level, lowest index on ties.
// Assumes the source index is the vector number; flags level-2 winners held in a valid match register.
module irq_arbiter
    import prio_irq_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int VEC_W   = 3
) (
    input  logic [NUM_SRC-1:0]             pend_i,
    input  src_cfg_t [NUM_SRC-1:0]         cfg_i,
    input  logic [1:0]                     mask_i,
    input  logic [FAST_N-1:0][VEC_W-1:0]   fm_vec_i,
    input  logic [FAST_N-1:0]              fm_valid_i,
    output logic                           win_valid_o,
    output logic [VEC_W-1:0]               win_idx_o,
    output logic [1:0]                     win_lvl_o,
    output logic                           win_fast_o
);

    // Scan from the top index down so an equal level at a lower index replaces the pick.
    always_comb begin
        win_valid_o = 1'b0;
        win_idx_o   = '0;
        win_lvl_o   = 2'd0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (pend_i[i] && cfg_i[i].enable && cfg_i[i].level >= mask_i &&
                (!win_valid_o || cfg_i[i].level >= win_lvl_o)) begin
                win_valid_o = 1'b1;
                win_idx_o   = VEC_W'(i);
                win_lvl_o   = cfg_i[i].level;
            end
        end
    end

    // Fast flag: level-2 winner matched by any valid match register.
    always_comb begin
        win_fast_o = 1'b0;
        for (int f = 0; f < FAST_N; f++) begin
            if (fm_valid_i[f] && fm_vec_i[f] == win_idx_o) win_fast_o = 1'b1;
        end
        win_fast_o = win_fast_o && win_valid_o && (win_lvl_o == 2'd2);
    end

endmodule

// File: rtl/prio_irq_ctrl.sv
// prio_irq_ctrl: top of the prioritized nested interrupt controller.
// Registers the arbiter's choice and holds it until the core acknowledges.
// Assumes irq_ack is asserted only in response to a presented request.
module prio_irq_ctrl
    import prio_irq_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int BASE_W  = 10,
    parameter int ADDR_W  = 5,
    parameter int DATA_W  = 16,
    localparam int VEC_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
    localparam int ADDR_O = BASE_W + VEC_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic [NUM_SRC-1:0] irq_req,
    input  logic [1:0]         core_mask,
    input  logic               irq_ack,
    output logic [ADDR_O-1:0]  irq_vec_addr,
    output logic [1:0]         irq_prio,
    output logic               irq_fast
);

    logic [BASE_W-1:0]            base;
    logic [FAST_N-1:0][VEC_W-1:0] fm_vec;
    logic [FAST_N-1:0]            fm_valid;
    src_cfg_t [NUM_SRC-1:0]       cfg;
    logic [NUM_SRC-1:0]           pend;
    logic [NUM_SRC-1:0]           ack_clr;
    logic                         win_valid, win_fast;
    logic [VEC_W-1:0]             win_idx;
    logic [1:0]                   win_lvl;
    logic                         busy;
    logic [VEC_W-1:0]             cur_idx;
    logic [1:0]                   cur_lvl;

    irq_regfile #(
        .NUM_SRC(NUM_SRC), .VEC_W(VEC_W), .BASE_W(BASE_W),
        .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .base_o(base), .fm_vec_o(fm_vec), .fm_valid_o(fm_valid), .cfg_o(cfg)
    );

    irq_pending #(.NUM_SRC(NUM_SRC)) u_pend (
        .clk(clk), .rst_n(rst_n), .req_i(irq_req), .cfg_i(cfg),
        .ack_clr_i(ack_clr), .pend_o(pend)
    );

    irq_arbiter #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) u_arb (
        .pend_i(pend), .cfg_i(cfg), .mask_i(core_mask),
        .fm_vec_i(fm_vec), .fm_valid_i(fm_valid),
        .win_valid_o(win_valid), .win_idx_o(win_idx),
        .win_lvl_o(win_lvl), .win_fast_o(win_fast)
    );

    // One-hot clear of the presented source when the core acknowledges.
    always_comb begin
        ack_clr = '0;
        if (busy && irq_ack) ack_clr[cur_idx] = 1'b1;
    end

    // Presentation register: load when idle, hold until acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy         <= 1'b0;
            cur_idx      <= '0;
            cur_lvl      <= 2'd0;
            irq_vec_addr <= '0;
            irq_prio     <= 2'b00;
            irq_fast     <= 1'b0;
        end else if (busy) begin
            if (irq_ack) begin
                busy     <= 1'b0;
                irq_prio <= 2'b00;
                irq_fast <= 1'b0;
            end
        end else if (win_valid) begin
            busy         <= 1'b1;
            cur_idx      <= win_idx;
            cur_lvl      <= win_lvl;
            irq_vec_addr <= {base, win_idx};
            irq_prio     <= prio_code(1'b1, win_lvl);
            irq_fast     <= win_fast;
        end
    end

    // A fresh presentation was admitted by the mask in force when it loaded.
    assert_mask_admits_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_prio != 2'b00 && $past(irq_prio) == 2'b00) |-> (cur_lvl >= $past(core_mask)));

    // The arbiter picks only enabled, pending, unmasked sources.
    assert_win_enabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> (cfg[win_idx].enable && pend[win_idx] && cfg[win_idx].level >= core_mask));

    // Presented outputs hold until acknowledged.
    assert_hold_until_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_prio != 2'b00 && !irq_ack) |=>
            ($stable(irq_prio) && $stable(irq_vec_addr) && $stable(irq_fast)));

    // An acknowledge of a presented request returns the code to idle.
    assert_ack_idles_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_prio != 2'b00 && irq_ack) |=> (irq_prio == 2'b00));

    // Fast flag only accompanies a level-2 presentation.
    assert_fast_level2_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_fast |-> (busy && cur_lvl == 2'd2));

endmodule

// File: tb/sim_prio_irq_ctrl.sv
module sim_prio_irq_ctrl;

    localparam int NSRC = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [NSRC-1:0] irq_req = '0;
    logic [1:0]  core_mask = 2'b00;
    logic        irq_ack = 1'b0;
    logic [12:0] irq_vec_addr;
    logic [1:0]  irq_prio;
    logic        irq_fast;

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    prio_irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_req(irq_req), .core_mask(core_mask), .irq_ack(irq_ack),
        .irq_vec_addr(irq_vec_addr), .irq_prio(irq_prio), .irq_fast(irq_fast)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [15:0] d);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        @(negedge clk);
        d = bus_rdata;
    endtask

    task automatic ack_once();
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
    endtask

    function automatic logic [1:0] code_of(input int lvl);
        return (lvl == 0) ? 2'b01 : (lvl == 1) ? 2'b10 : 2'b11;
    endfunction

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected<100000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        int base;
        step(3);
        rst_n = 1'b1;
        step(1);

        // R1 reset state.
        chk("R1 prio", irq_prio, 2'b00);
        chk("R1 fast", irq_fast, 1'b0);
        chk("R1 addr", irq_vec_addr, 0);
        rd(5'd0, d); chk("R1 base", d, 0);
        rd(5'd1, d); chk("R1 fm0", d, 0);
        rd(5'd4, d); chk("R1 src0", d, 0);

        // R11 readback.
        wr(5'd0, 16'h02A5); rd(5'd0, d); chk("R11 base", d, 16'h02A5);
        wr(5'd2, 16'h8005); rd(5'd2, d); chk("R11 fm1", d, 16'h8005);
        wr(5'd9, 16'h000E); rd(5'd9, d); chk("R11 src5", d, 16'h000E);
        wr(5'd9, 16'h0000); wr(5'd2, 16'h0000);
        base = 16'h02A5;

        // R8 edge timing: source 3 edge-mode level 1.
        wr(5'd7, 16'h000D);
        irq_req[3] = 1'b1;
        @(negedge clk);
        irq_req[3] = 1'b0;
        chk("R8 not yet", irq_prio, 2'b00);
        @(negedge clk);
        chk("R8 presented", irq_prio, 2'b10);
        chk("R2 addr src3", irq_vec_addr, base * 8 + 3);
        ack_once();
        chk("R7 idle after ack", irq_prio, 2'b00);
        step(3);
        chk("R8 edge cleared", irq_prio, 2'b00);

        // R8 level mode: source 3 re-presents while request stays high.
        wr(5'd7, 16'h0005);
        irq_req[3] = 1'b1;
        step(3);
        chk("R8 level present", irq_prio, 2'b10);
        ack_once();
        chk("R8 level ack idle", irq_prio, 2'b00);
        @(negedge clk);
        chk("R8 level again", irq_prio, 2'b10);
        irq_req[3] = 1'b0;
        ack_once();
        step(2);
        wr(5'd7, 16'h0000);

        // R7 hold: source 2 level 1, then source 6 level 3 arrives.
        wr(5'd6, 16'h0005);
        wr(5'd10, 16'h0007);
        irq_req[2] = 1'b1;
        step(3);
        chk("R7 first", irq_vec_addr, base * 8 + 2);
        irq_req[6] = 1'b1;
        step(3);
        chk("R7 held addr", irq_vec_addr, base * 8 + 2);
        chk("R7 held prio", irq_prio, 2'b10);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
        chk("R7 ack idle", irq_prio, 2'b00);
        @(negedge clk);
        chk("R5 higher next", irq_vec_addr, base * 8 + 6);
        chk("R4 level3 code", irq_prio, 2'b11);
        irq_req = '0;
        ack_once();
        step(2);

        // R7 idle ack ignored: masked edge source 7 stays pending.
        wr(5'd11, 16'h000C);
        core_mask = 2'b11;
        irq_req[7] = 1'b1;
        @(negedge clk);
        irq_req[7] = 1'b0;
        step(2);
        chk("R3 mask11 blocks lvl0", irq_prio, 2'b00);
        ack_once();
        step(1);
        core_mask = 2'b00;
        step(2);
        chk("R7 idle ack no effect", irq_prio, 2'b01);
        chk("R2 addr src7", irq_vec_addr, base * 8 + 7);
        ack_once();
        step(3);
        chk("R8 edge src7 cleared", irq_prio, 2'b00);
        wr(5'd11, 16'h0000); wr(5'd6, 16'h0000); wr(5'd10, 16'h0000);

        // R10 nesting: source 1 level 0 in service, mask raised to 01.
        wr(5'd5, 16'h0004);
        wr(5'd9, 16'h0006);
        irq_req[1] = 1'b1;
        step(3);
        chk("R10 first lvl0", irq_prio, 2'b01);
        irq_ack = 1'b1; core_mask = 2'b01;
        @(negedge clk);
        irq_ack = 1'b0;
        step(2);
        chk("R10 lvl0 withheld", irq_prio, 2'b00);
        irq_req[5] = 1'b1;
        step(3);
        chk("R10 nested lvl2", irq_prio, 2'b11);
        chk("R10 nested addr", irq_vec_addr, base * 8 + 5);
        irq_req = '0;
        ack_once();
        core_mask = 2'b00;
        step(2);
        wr(5'd5, 16'h0000); wr(5'd9, 16'h0000);

        // R9 directed: invalid match with vector 0 never flags.
        wr(5'd4, 16'h0006);
        irq_req[0] = 1'b1;
        step(3);
        chk("R9 invalid fm no fast", irq_fast, 1'b0);
        irq_req = '0; ack_once(); step(2);
        wr(5'd1, 16'h8000);
        irq_req[0] = 1'b1;
        step(3);
        chk("R9 valid fm fast", irq_fast, 1'b1);
        irq_req = '0; ack_once(); step(2);
        wr(5'd4, 16'h0007);
        irq_req[0] = 1'b1;
        step(3);
        chk("R9 level3 not fast", irq_fast, 1'b0);
        irq_req = '0; ack_once(); step(2);

        // Sweep: R2 R3 R4 R5 R6 R9 over mixed configurations and masks.
        for (int t = 0; t < 64; t++) begin
            int lvl[NSRC];
            int en[NSRC];
            int best, blvl, fm0, fm1, fm0v, efast;
            logic [NSRC-1:0] rq;
            base = (t * 13 + 5) & 10'h3FF;
            wr(5'd0, 16'(base));
            fm0 = (t * 5 + 3) % 8; fm0v = t & 1;
            fm1 = t % 8;
            wr(5'd1, 16'((fm0v << 15) | fm0));
            wr(5'd2, 16'(32768 | fm1));
            for (int i = 0; i < NSRC; i++) begin
                lvl[i] = (t + i * 3 + (t >> 3) * i) & 3;
                en[i]  = (((t * 3 + i) % 7) != 0) ? 1 : 0;
                rq[i]  = (((t * 5 + i * 7 + (t >> 4)) % 3) != 0);
                wr(5'(4 + i), 16'((en[i] << 2) | lvl[i]));
            end
            best = -1; blvl = 0;
            for (int i = 0; i < NSRC; i++) begin
                if (rq[i] && en[i] == 1 && lvl[i] >= (t & 3) &&
                    (best < 0 || lvl[i] > blvl)) begin
                    best = i; blvl = lvl[i];
                end
            end
            efast = (best >= 0 && blvl == 2 &&
                     ((fm0v == 1 && fm0 == best) || fm1 == best)) ? 1 : 0;
            core_mask = 2'(t & 3);
            irq_req = rq;
            step(3);
            if (best < 0) begin
                chk("R3 R6 none", irq_prio, 2'b00);
            end else begin
                chk("R4 R5 code", irq_prio, code_of(blvl));
                chk("R2 R5 addr", irq_vec_addr, base * 8 + best);
                chk("R9 fast", irq_fast, efast);
            end
            irq_req = '0;
            if (best >= 0) ack_once();
            step(2);
        end

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule